// File: doc/BRIEF.md
# Byte-port network adapter, device side

This block is the device half of a small memory-mapped network adapter. A host reads and writes 32-bit registers at word offsets. Through them it can read an identification word, a busy flag, a receive byte count, a transmit byte count, interrupt control and a constant routing word. It also has one byte-wide data port for each direction. On the network side the block takes frames from an incoming byte stream and sends frames on an outgoing byte stream. Both streams use valid/ready handshakes, and each direction has a buffer that holds one frame.

To receive, the host waits for the rx-available interrupt and reads the receive count. It then reads the receive data port once per byte. Each read returns the next byte and lowers the count by one. The host then writes 1 to bit 1 of interrupt control, which lets the next frame in. To transmit, the host writes the frame length to the transmit count and then writes that many bytes to the transmit data port. The block sends the frame, clears the count, and raises tx-done one cycle later. Interrupt control bit 31 is a self-test source for checking the interrupt path.

Stream rules: a byte moves on a clock edge where valid and ready are both high. The block holds `rxs_ready` low while a received frame is still owned by the host. `txs_valid`, `txs_data` and `txs_last` stay stable until the sink takes the byte. `rxs_last` and `txs_last` mark the final byte of a frame.

Top module: `netport_dev`

## Requirements
- R1: Reading offset 0x00 returns 32'h5350494D and offset 0x04 returns 32'h3054454E. Together they form a 64-bit identification word whose least significant byte is 8'h4D. Offset 0x18 returns the INFO parameter. Unmapped offsets read 0.
- R2: After reset the following all read 0: receive count (0x0C), transmit count (0x10), busy (0x08, bit 0) and interrupt control (0x14). Also after reset `irq` and `txs_valid` are low and `rxs_ready` is high.
- R3: When the last byte of an incoming frame is accepted, the receive count becomes the frame length and interrupt control bit 1 is set. Each read of the receive data port (0x1C) returns the next byte of the frame in bits 7:0, in arrival order, and lowers the count by one.
- R4: A read of the receive data port while the receive count is 0 returns 0 and changes no counter.
- R5: `rxs_ready` is low while interrupt control bit 1 is set or the receive count is non-zero. Bytes of a frame beyond the buffer depth DEPTH are dropped, and the count then equals DEPTH.
- R6: The host writes N to the transmit count (0x10) and then writes N bytes to the transmit data port (0x20), of which only bits 7:0 are used. After the N-th byte, the frame is offered on the outgoing stream in order, with `txs_last` set only on byte N. The transmit count clears on the final handshake, and interrupt control bit 0 is set one cycle later.
- R7: Transmit data writes beyond the programmed count are dropped. A transmit count write is ignored while a frame is being sent. A count above DEPTH is stored as DEPTH.
- R8: Writing 1 to interrupt control bit 0 or bit 1 clears that bit. `irq` is high while bit 0, bit 1 or the test interrupt is set.
- R9: A write with bit 31 set raises the test interrupt. The next read of interrupt control shows bit 31 set and clears it, so a second read shows it clear. `irq` stays high until a write of 32'h0 to interrupt control.
- R10: Busy bit 0 is 1 while an incoming frame has been partly accepted and while an outgoing frame is being offered, and 0 otherwise.
- R11: While `txs_valid` is high and `txs_ready` is low, `txs_valid`, `txs_data` and `txs_last` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Register read strobe, one per cycle |
| bus_wr | input | 1 | Register write strobe, one per cycle |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| rxs_valid | input | 1 | Incoming byte valid |
| rxs_ready | output | 1 | Block can accept an incoming byte |
| rxs_data | input | 8 | Incoming byte |
| rxs_last | input | 1 | Incoming byte ends its frame |
| txs_valid | output | 1 | Outgoing byte valid |
| txs_ready | input | 1 | Sink accepts the outgoing byte |
| txs_data | output | 8 | Outgoing byte |
| txs_last | output | 1 | Outgoing byte ends its frame |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH set to 16 and INFO set to 5. With a depth of 16, an oversize incoming frame of 20 bytes and a transmit count clamped from 100 both fit in a few dozen cycles. They show the truncation and clamping limits at the buffer edge rather than at the full 65536-byte count range. The non-zero INFO value shows that the routing word comes from the parameter and is not a reset default.

// File: rtl/netport_pkg.sv
package netport_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFF_ID_LO  = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_ID_HI  = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_BUSY   = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_RXCNT  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_TXCNT  = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_CTL    = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_INFO   = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_RXDATA = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_TXDATA = 6'h20;

  localparam int CTL_TX_BIT   = 0;
  localparam int CTL_RX_BIT   = 1;
  localparam int CTL_TEST_BIT = 31;

  localparam int MAX_COUNT = 65536;
  localparam int CNT_W     = $clog2(MAX_COUNT + 1);
endpackage

// File: rtl/netport_rx.sv
module netport_rx #(
  parameter int DEPTH = 64,
  parameter int CW    = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  input  logic          hold,
  input  logic          pop,
  output logic [CW-1:0] count,
  output logic [7:0]    head,
  output logic          frame_done,
  output logic          in_frame
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] wr_len;
  logic [CW-1:0] rd_ptr;
  logic          take;
  logic          room;
  logic [CW-1:0] final_len;

  assign s_ready    = !hold && (count == '0);
  assign take       = s_valid && s_ready;
  assign room       = wr_len < DEPTH_C;
  assign final_len  = room ? wr_len + 1'b1 : wr_len;
  assign frame_done = take && s_last;
  assign head       = (count != '0) ? mem[rd_ptr[PW-1:0]] : 8'h00;

  always_ff @(posedge clk) begin
    if (take && room) mem[wr_len[PW-1:0]] <= s_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_len   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      in_frame <= 1'b0;
    end else if (take) begin
      if (s_last) begin
        count    <= final_len;
        wr_len   <= '0;
        rd_ptr   <= '0;
        in_frame <= 1'b0;
      end else begin
        wr_len   <= final_len;
        in_frame <= 1'b1;
      end
    end else if (pop && count != '0) begin
      count  <= count - 1'b1;
      rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/netport_tx.sv
module netport_tx #(
  parameter int DEPTH = 64,
  parameter int CW    = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          len_wr,
  input  logic [31:0]   len_data,
  input  logic          byte_wr,
  input  logic [7:0]    byte_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [7:0]    m_data,
  output logic          m_last,
  output logic [CW-1:0] count,
  output logic          sending,
  output logic          done
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [31:0]   DEPTH_W = 32'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] fill;
  logic [CW-1:0] send_ptr;
  logic          load;
  logic          fire;
  logic [CW-1:0] len_clamped;

  assign len_clamped = (len_data > DEPTH_W) ? CW'(DEPTH) : len_data[CW-1:0];
  assign load        = byte_wr && !sending && (fill < count);
  assign m_valid     = sending;
  assign m_data      = mem[send_ptr[PW-1:0]];
  assign m_last      = sending && (send_ptr == count - 1'b1);
  assign fire        = m_valid && m_ready;

  always_ff @(posedge clk) begin
    if (load) mem[fill[PW-1:0]] <= byte_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      fill     <= '0;
      send_ptr <= '0;
      sending  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= fire && m_last;
      if (sending) begin
        if (fire) begin
          if (m_last) begin
            sending <= 1'b0;
            count   <= '0;
            fill    <= '0;
          end else begin
            send_ptr <= send_ptr + 1'b1;
          end
        end
      end else if (len_wr) begin
        count <= len_clamped;
        fill  <= '0;
      end else if (load) begin
        fill <= fill + 1'b1;
        if (fill + 1'b1 == count) begin
          sending  <= 1'b1;
          send_ptr <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/netport_irq.sv
module netport_irq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic        ctl_rd,
  input  logic [31:0] wdata,
  input  logic        tx_set,
  input  logic        rx_set,
  output logic        tx_flag,
  output logic        rx_flag,
  output logic        test_seen,
  output logic        test_line,
  output logic        irq
);
  import netport_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_flag   <= 1'b0;
      rx_flag   <= 1'b0;
      test_seen <= 1'b0;
      test_line <= 1'b0;
    end else begin
      if (tx_set) tx_flag <= 1'b1;
      else if (ctl_wr && wdata[CTL_TX_BIT]) tx_flag <= 1'b0;

      if (rx_set) rx_flag <= 1'b1;
      else if (ctl_wr && wdata[CTL_RX_BIT]) rx_flag <= 1'b0;

      if (ctl_wr && wdata[CTL_TEST_BIT]) test_seen <= 1'b1;
      else if (ctl_rd) test_seen <= 1'b0;

      if (ctl_wr) begin
        if (wdata == 32'h0) test_line <= 1'b0;
        else if (wdata[CTL_TEST_BIT]) test_line <= 1'b1;
      end
    end
  end

  assign irq = tx_flag || rx_flag || test_line;
endmodule

// File: rtl/netport_dev.sv
module netport_dev #(
  parameter int          DEPTH  = 64,
  parameter logic [63:0] DEV_ID = 64'h3054_454E_5350_494D,
  parameter logic [31:0] INFO   = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rxs_valid,
  output logic        rxs_ready,
  input  logic [7:0]  rxs_data,
  input  logic        rxs_last,
  output logic        txs_valid,
  input  logic        txs_ready,
  output logic [7:0]  txs_data,
  output logic        txs_last,
  output logic        irq
);
  import netport_pkg::*;
  localparam int CW = CNT_W;

  logic [CW-1:0] rx_cnt, tx_cnt;
  logic [7:0]    rx_head;
  logic          rx_done, rx_busy, tx_busy, tx_done;
  logic          tx_flag, rx_flag, test_seen, test_line;
  logic          rx_pop, ctl_rd, ctl_wr, txlen_wr, txbyte_wr;

  assign rx_pop    = bus_rd && bus_addr == OFF_RXDATA;
  assign ctl_rd    = bus_rd && bus_addr == OFF_CTL;
  assign ctl_wr    = bus_wr && bus_addr == OFF_CTL;
  assign txlen_wr  = bus_wr && bus_addr == OFF_TXCNT;
  assign txbyte_wr = bus_wr && bus_addr == OFF_TXDATA;

  netport_rx #(.DEPTH(DEPTH), .CW(CW)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .s_valid(rxs_valid), .s_ready(rxs_ready), .s_data(rxs_data), .s_last(rxs_last),
    .hold(rx_flag), .pop(rx_pop),
    .count(rx_cnt), .head(rx_head), .frame_done(rx_done), .in_frame(rx_busy)
  );

  netport_tx #(.DEPTH(DEPTH), .CW(CW)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .len_wr(txlen_wr), .len_data(bus_wdata),
    .byte_wr(txbyte_wr), .byte_data(bus_wdata[7:0]),
    .m_valid(txs_valid), .m_ready(txs_ready), .m_data(txs_data), .m_last(txs_last),
    .count(tx_cnt), .sending(tx_busy), .done(tx_done)
  );

  netport_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .wdata(bus_wdata),
    .tx_set(tx_done), .rx_set(rx_done),
    .tx_flag(tx_flag), .rx_flag(rx_flag),
    .test_seen(test_seen), .test_line(test_line), .irq(irq)
  );

  always_comb begin
    bus_rdata = 32'h0;
    if (bus_rd) begin
      unique case (bus_addr)
        OFF_ID_LO:  bus_rdata = DEV_ID[31:0];
        OFF_ID_HI:  bus_rdata = DEV_ID[63:32];
        OFF_BUSY:   bus_rdata = {31'h0, rx_busy || tx_busy};
        OFF_RXCNT:  bus_rdata = 32'(rx_cnt);
        OFF_TXCNT:  bus_rdata = 32'(tx_cnt);
        OFF_CTL:    bus_rdata = {test_seen, 29'h0, rx_flag, tx_flag};
        OFF_INFO:   bus_rdata = INFO;
        OFF_RXDATA: bus_rdata = {24'h0, rx_head};
        default:    bus_rdata = 32'h0;
      endcase
    end
  end
endmodule

// File: rtl/netport_chk.sv
module netport_chk #(
  parameter int CW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rd,
  input logic [5:0]    bus_addr,
  input logic [31:0]   bus_rdata,
  input logic          rxs_ready,
  input logic          txs_valid,
  input logic          txs_ready,
  input logic [7:0]    txs_data,
  input logic          txs_last,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic          rx_flag,
  input logic          tx_flag
);
  a_r3_rx_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 6'h1C && rx_cnt != '0) |=> rx_cnt == $past(rx_cnt) - 1'b1);

  a_r4_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 6'h1C && rx_cnt == '0) |-> bus_rdata == 32'h0);

  a_r5_hold_blocks_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag || rx_cnt != '0) |-> !rxs_ready);

  a_r6_count_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (txs_valid && txs_ready && txs_last) |=> tx_cnt == '0 && !txs_valid);

  a_r6_done_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (txs_valid && txs_ready && txs_last) |=> ##1 tx_flag);

  a_r11_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (txs_valid && !txs_ready) |=> txs_valid && $stable(txs_data) && $stable(txs_last));
endmodule

bind netport_dev netport_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .rxs_ready(rxs_ready), .txs_valid(txs_valid), .txs_ready(txs_ready),
  .txs_data(txs_data), .txs_last(txs_last),
  .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .rx_flag(rx_flag), .tx_flag(tx_flag)
);

// File: tb/tb_netport_dev.sv
module tb_netport_dev;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam logic [31:0] INFO = 32'h0000_0005;

  // vector: {frame length, first byte, expected rx count}
  localparam int NVEC = 5;
  localparam logic [23:0] VEC [NVEC] = '{
    {8'd1,  8'h10, 8'd1},
    {8'd4,  8'hA0, 8'd4},
    {8'd9,  8'h33, 8'd9},
    {8'd16, 8'hF8, 8'd16},
    {8'd20, 8'h40, 8'd16}
  };

  logic clk = 0, rst_n = 0;
  logic bus_rd = 0, bus_wr = 0;
  logic [5:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic rxs_valid = 0, rxs_ready, rxs_last = 0;
  logic [7:0] rxs_data = 0;
  logic txs_valid, txs_ready = 0, txs_last;
  logic [7:0] txs_data;
  logic irq;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] cap [32];
  int ncap = 0, last_pos = -1, nlast = 0;

  always #(PERIOD/2) clk = ~clk;

  netport_dev #(.DEPTH(DEPTH), .INFO(INFO)) dut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxs_valid(rxs_valid), .rxs_ready(rxs_ready), .rxs_data(rxs_data), .rxs_last(rxs_last),
    .txs_valid(txs_valid), .txs_ready(txs_ready), .txs_data(txs_data), .txs_last(txs_last),
    .irq(irq)
  );

  always @(negedge clk) begin
    if (txs_valid && txs_ready && ncap < 32) begin
      cap[ncap] = txs_data;
      if (txs_last) begin last_pos = ncap; nlast++; end
      ncap++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic put_byte(input logic [7:0] b, input logic last);
    int guard = 0;
    @(negedge clk);
    while (!rxs_ready && guard < 200) begin @(negedge clk); guard++; end
    rxs_valid = 1; rxs_data = b; rxs_last = last;
    @(posedge clk); #1;
    rxs_valid = 0; rxs_last = 0;
  endtask

  task automatic send_frame(input int len, input logic [7:0] seed);
    for (int i = 0; i < len; i++) put_byte(seed + 8'(i), i == len - 1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_n = 1;
    idle(1);

    // R2 reset state
    #1;
    check("R2 irq", {31'h0, irq}, 0);
    check("R2 rxs_ready", {31'h0, rxs_ready}, 1);
    check("R2 txs_valid", {31'h0, txs_valid}, 0);
    rd(6'h08, d); check("R2 busy", d, 0);
    rd(6'h0C, d); check("R2 rx count", d, 0);
    rd(6'h10, d); check("R2 tx count", d, 0);
    rd(6'h14, d); check("R2 ctl", d, 0);

    // R1 identification and info
    rd(6'h00, d); check("R1 id low", d, 32'h5350494D);
    rd(6'h04, d); check("R1 id high", d, 32'h3054454E);
    rd(6'h18, d); check("R1 info", d, INFO);
    rd(6'h24, d); check("R1 unmapped", d, 0);

    // R3 R4 R5 R8: receive vector loop
    for (int v = 0; v < NVEC; v++) begin
      int len = int'(VEC[v][23:16]);
      logic [7:0] seed = VEC[v][15:8];
      int expc = int'(VEC[v][7:0]);
      send_frame(len, seed);
      idle(1);
      rd(6'h0C, d); check("R3 rx count loaded", d, expc);
      rd(6'h14, d); check("R3 ctl rx bit", d, 32'h2);
      check("R8 irq on rx", {31'h0, irq}, 1);
      for (int i = 0; i < expc; i++) begin
        rd(6'h1C, d); check("R3 rx byte", d, {24'h0, seed + 8'(i)});
      end
      rd(6'h0C, d); check("R3 rx count drained", d, 0);
      rd(6'h1C, d); check("R4 empty read", d, 0);
      rd(6'h0C, d); check("R4 count unchanged", d, 0);
      wr(6'h14, 32'h2);
      rd(6'h14, d); check("R8 rx bit cleared", d, 0);
      check("R8 irq low", {31'h0, irq}, 0);
    end

    // R5 hold while bit 1 set
    send_frame(3, 8'h70);
    idle(1);
    check("R5 ready low with data", {31'h0, rxs_ready}, 0);
    for (int i = 0; i < 3; i++) rd(6'h1C, d);
    idle(1);
    check("R5 ready low while bit1 set", {31'h0, rxs_ready}, 0);
    wr(6'h14, 32'h2);
    idle(1);
    check("R5 ready after clear", {31'h0, rxs_ready}, 1);
    // R5 hold while count non-zero
    send_frame(2, 8'h55);
    wr(6'h14, 32'h2);
    idle(1);
    check("R5 ready low with count", {31'h0, rxs_ready}, 0);
    rd(6'h1C, d); check("R5 byte after early clear", d, 32'h55);
    rd(6'h1C, d);
    idle(1);
    check("R5 ready after drain", {31'h0, rxs_ready}, 1);

    // R10 busy during partial receive
    put_byte(8'h01, 0);
    put_byte(8'h02, 0);
    rd(6'h08, d); check("R10 busy rx partial", d, 1);
    put_byte(8'h03, 1);
    rd(6'h08, d); check("R10 busy rx done", d, 0);
    for (int i = 0; i < 3; i++) rd(6'h1C, d);
    wr(6'h14, 32'h2);

    // R6 R7 R10 R11 transmit
    txs_ready = 0;
    wr(6'h10, 5);
    rd(6'h10, d); check("R6 tx count set", d, 5);
    for (int i = 0; i < 3; i++) wr(6'h20, 32'hFFFF_FF00 | (32'hC0 + i));
    rd(6'h08, d); check("R10 busy while loading", d, 0);
    for (int i = 3; i < 5; i++) wr(6'h20, 32'hC0 + i);
    idle(1);
    check("R6 valid after fill", {31'h0, txs_valid}, 1);
    rd(6'h08, d); check("R10 busy while sending", d, 1);
    idle(3);
    check("R11 data held", {24'h0, txs_data}, 32'hC0);
    check("R11 valid held", {31'h0, txs_valid}, 1);
    wr(6'h10, 9);
    rd(6'h10, d); check("R7 count write ignored while sending", d, 5);
    wr(6'h20, 32'hEE);
    wr(6'h20, 32'hEF);
    @(negedge clk); txs_ready = 1;
    idle(12);
    check("R7 captured count", ncap, 5);
    for (int i = 0; i < 5; i++) check("R6 tx byte order", {24'h0, cap[i]}, 32'hC0 + i);
    check("R6 last position", last_pos, 4);
    check("R6 single last", nlast, 1);
    rd(6'h10, d); check("R6 tx count cleared", d, 0);
    rd(6'h14, d); check("R6 tx done bit", d, 32'h1);
    check("R8 irq on tx", {31'h0, irq}, 1);
    wr(6'h14, 32'h1);
    rd(6'h14, d); check("R8 tx bit cleared", d, 0);

    // R7 clamp
    wr(6'h10, 100);
    rd(6'h10, d); check("R7 count clamped", d, DEPTH);
    wr(6'h10, 0);
    rd(6'h10, d); check("R7 count rewritten", d, 0);

    // R9 self-test interrupt
    wr(6'h14, 32'h8000_0000);
    #1 check("R9 irq raised", {31'h0, irq}, 1);
    rd(6'h14, d); check("R9 first read", d, 32'h8000_0000);
    rd(6'h14, d); check("R9 second read", d, 0);
    #1 check("R9 irq kept", {31'h0, irq}, 1);
    wr(6'h14, 32'h0);
    #1 check("R9 irq dropped", {31'h0, irq}, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule